// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads one or two descriptors from a table in memory, then decides whether the access is allowed. Descriptors are fetched through a plain read port: the walker raises a request with an address and holds it until the port accepts it, and the port returns the data with a one-cycle valid strobe. A first-level entry is one of three kinds:
- a fault entry;
- a 1 MB section, which ends the walk;
- a pointer to a second-level table, either coarse or fine.

A second-level entry maps a 64 KB, 4 KB or 1 KB page. Large and small pages carry four permission fields, one for each quarter of the page.

Each request carries:
- the virtual address;
- the access kind (read, write or instruction fetch);
- a user/privileged flag.

The configuration inputs, sampled when a request is accepted, are:
- the table base;
- the domain access word;
- the translation enable;
- the two-bit mode that governs permission value 0;
- the process ID. It is added to any address that falls inside the low 32 MB window before the walk starts.

The block accepts one walk at a time. It answers with a single-cycle result strobe that carries either a physical address with read and write grants, or a nonzero fault status word. That word holds the fault code in its low nibble and the domain number in its high nibble.

Top module: `walker_top`

## Requirements
- R1: After reset, `res_valid`, `busy` and `mem_req_valid` are all low.
- R2: A virtual address below 0x0200_0000 has `cfg_pid` added to it before translation; an address at or above 0x0200_0000 is used unchanged.
- R3: With `cfg_xlat_en` low, the result arrives without any memory read, its physical address equals the relocated virtual address, and it grants read and write.
- R4: The first-level descriptor is read from {`cfg_tbl_base`, va[31:20], 2'b00}; its type is in bits 1:0 (0 fault, 1 coarse table, 2 section, 3 fine table); type 0 yields fault code 5.
- R5: The domain number is descriptor bits 8:5 and selects bits [2d+1:2d] of `cfg_dom_acc`; a field value of 0 or 2 yields fault code 9 for a section and 11 for a table pointer.
- R6: A section maps to {desc[31:20], va[19:0]} with permission value desc[11:10]; a failed permission check yields code 13.
- R7: The second-level descriptor is read from {desc[31:10], va[19:12], 2'b00}; second-level type 0 yields code 7, and type 3 (1 KB page) reached through a coarse table (first-level type 1) also yields code 7.
- R8: Second-level type 1 maps {desc[31:16], va[15:0]} and type 2 maps {desc[31:12], va[11:0]}, both with permission value desc[5+2q:4+2q] where q = va[15:14]; type 3 maps {desc[31:10], va[9:0]} with permission value desc[5:4]; a failed page permission check yields code 15.
- R9: Domain field 3 grants read and write regardless of permission value; permission value 1 grants read/write to privileged accesses and nothing to user accesses; permission value 2 grants read/write to privileged, read only to user reads, and nothing to user writes; permission value 3 grants read and write.
- R10: Permission value 0 grants nothing to a write (`req_acc` = 2'b01); for reads and fetches, `cfg_rom_mode` 1 grants read to privileged accesses only, 2 grants read to all, and 0 or 3 grants nothing.
- R11: `res_status` is the fault code ORed with the domain number shifted left by 4, `res_fault` is high exactly when it is nonzero, and a successful walk reports status 0.
- R12: Only one walk is in flight: `busy` is high from acceptance until the result, requests seen while busy are dropped, `res_valid` is a single-cycle pulse, and a memory request stays asserted with a steady address until `mem_req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a walk (taken when not busy) |
| req_va | input | 32 | Virtual address |
| req_acc | input | 2 | 00 read, 01 write, 10 fetch, 11 treated as read |
| req_user | input | 1 | 1 for an unprivileged access |
| cfg_tbl_base | input | 18 | First-level table base, address bits 31:14 |
| cfg_dom_acc | input | 32 | Sixteen 2-bit domain fields |
| cfg_xlat_en | input | 1 | Translation enable |
| cfg_rom_mode | input | 2 | Mode for permission value 0 |
| cfg_pid | input | 32 | Process ID added to low addresses |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Read port accepts the request |
| mem_req_addr | output | 32 | Descriptor address |
| mem_rsp_valid | input | 1 | Descriptor data valid |
| mem_rsp_data | input | 32 | Descriptor data |
| res_valid | output | 1 | One-cycle result strobe |
| res_fault | output | 1 | Walk ended in a fault |
| res_pa | output | 32 | Physical address |
| res_rd | output | 1 | Read granted |
| res_wr | output | 1 | Write granted |
| res_status | output | 8 | Fault status, domain in bits 7:4 |

## Verification
The walker is tried on three table shapes:
- sections;
- a coarse table holding large, small and 1 KB page entries;
- a fine table holding a 1 KB page.

Each shape is paired with domain fields 0, 1, 2 and 3, so domain faults are told apart from permission faults and from manager bypass. Accesses go through every permission value as user and as privileged reads and writes, with the permission value 0 mode swept. This separates rules that differ only in the user flag or the access kind. A quarter-page permission pick with a nonzero va[15:14] shows whether the field shift is taken from the right address bits. A read port that stalls every other cycle and a request held during a walk show whether request holding works and whether only one result is produced.

// File: rtl/walker_pkg.sv
package walker_pkg;

   typedef enum logic [2:0] {
      WS_IDLE,
      WS_L1_REQ,
      WS_L1_WAIT,
      WS_L2_REQ,
      WS_L2_WAIT,
      WS_FIN
   } walk_state_e;

   typedef enum logic [1:0] {
      ACC_READ  = 2'b00,
      ACC_WRITE = 2'b01,
      ACC_FETCH = 2'b10,
      ACC_RSVD  = 2'b11
   } acc_e;

   // first-level descriptor kinds
   localparam logic [1:0] L1K_FAULT   = 2'd0;
   localparam logic [1:0] L1K_COARSE  = 2'd1;
   localparam logic [1:0] L1K_SECTION = 2'd2;
   localparam logic [1:0] L1K_FINE    = 2'd3;

   // second-level descriptor kinds
   localparam logic [1:0] L2K_FAULT = 2'd0;
   localparam logic [1:0] L2K_LARGE = 2'd1;
   localparam logic [1:0] L2K_SMALL = 2'd2;
   localparam logic [1:0] L2K_TINY  = 2'd3;

   // fault codes (low nibble of the status word)
   localparam logic [3:0] FC_L1_TRANS = 4'd5;
   localparam logic [3:0] FC_L2_TRANS = 4'd7;
   localparam logic [3:0] FC_SEC_DOM  = 4'd9;
   localparam logic [3:0] FC_TBL_DOM  = 4'd11;
   localparam logic [3:0] FC_SEC_PERM = 4'd13;
   localparam logic [3:0] FC_PG_PERM  = 4'd15;

   typedef struct packed {
      logic rd;
      logic wr;
   } grant_t;

endpackage

// File: rtl/walker_perm.sv
module walker_perm
   import walker_pkg::*;
(
   input  logic [1:0] dom_field,
   input  logic [1:0] ap,
   input  logic       is_write,
   input  logic       is_user,
   input  logic [1:0] rom_mode,
   output grant_t     grant
);

   always_comb begin
      grant = '{rd: 1'b0, wr: 1'b0};
      if (dom_field == 2'd3) begin
         grant = '{rd: 1'b1, wr: 1'b1};
      end else begin
         unique case (ap)
            2'd0: begin
               if (!is_write) begin
                  unique case (rom_mode)
                     2'd1:    grant.rd = !is_user;
                     2'd2:    grant.rd = 1'b1;
                     default: grant.rd = 1'b0;
                  endcase
               end
            end
            2'd1: begin
               grant.rd = !is_user;
               grant.wr = !is_user;
            end
            2'd2: begin
               grant.rd = !(is_user && is_write);
               grant.wr = !is_user;
            end
            default: grant = '{rd: 1'b1, wr: 1'b1};
         endcase
      end
   end

   // R10
   always_comb begin
      if (dom_field != 2'd3 && ap == 2'd0 && is_write)
         ap0_no_write_chk: assert (!grant.rd && !grant.wr);
   end

endmodule

// File: rtl/walker_dom_sel.sv
module walker_dom_sel #(
   parameter int N_DOM = 16,
   localparam int IDX_W = $clog2(N_DOM)
) (
   input  logic [2*N_DOM-1:0] dom_reg,
   input  logic [IDX_W-1:0]   idx,
   output logic [1:0]         field
);

   logic [1:0] fields [N_DOM];

   for (genvar d = 0; d < N_DOM; d++) begin : g_field
      assign fields[d] = dom_reg[2*d +: 2];
   end

   assign field = fields[idx];

endmodule

// File: rtl/walker_l1_decode.sv
module walker_l1_decode
   import walker_pkg::*;
#(
   parameter int DOM_IDX_W = 4
) (
   input  logic [31:0]          desc,
   input  logic [19:0]          va_lo,
   output logic [1:0]           kind,
   output logic [DOM_IDX_W-1:0] dom_idx,
   output logic [31:0]          sec_pa,
   output logic [1:0]           sec_ap,
   output logic [31:0]          l2_addr
);

   logic unused_l1_bits;
   assign unused_l1_bits = ^{desc[9], desc[4:2], desc[19:12]};

   assign kind    = desc[1:0];
   assign dom_idx = desc[5 +: DOM_IDX_W];
   assign sec_pa  = {desc[31:20], va_lo[19:0]};
   assign sec_ap  = desc[11:10];
   assign l2_addr = {desc[31:10], va_lo[19:12], 2'b00};

endmodule

// File: rtl/walker_l2_decode.sv
module walker_l2_decode
   import walker_pkg::*;
(
   input  logic [31:0] desc,
   input  logic [15:0] va_lo,
   input  logic        l1_fine,
   output logic [31:0] pa,
   output logic [1:0]  ap,
   output logic        trans_fault
);

   logic [1:0] quarter_ap;
   logic       unused_l2_bits;

   assign unused_l2_bits = ^desc[3:2];

   always_comb begin
      unique case (va_lo[15:14])
         2'd0:    quarter_ap = desc[5:4];
         2'd1:    quarter_ap = desc[7:6];
         2'd2:    quarter_ap = desc[9:8];
         default: quarter_ap = desc[11:10];
      endcase
   end

   always_comb begin
      pa          = '0;
      ap          = quarter_ap;
      trans_fault = 1'b0;
      unique case (desc[1:0])
         L2K_FAULT: trans_fault = 1'b1;
         L2K_LARGE: pa = {desc[31:16], va_lo[15:0]};
         L2K_SMALL: pa = {desc[31:12], va_lo[11:0]};
         default: begin
            pa          = {desc[31:10], va_lo[9:0]};
            ap          = desc[5:4];
            trans_fault = !l1_fine;
         end
      endcase
   end

endmodule

// File: rtl/walker_top.sv
module walker_top
   import walker_pkg::*;
#(
   parameter int              ADDR_W     = 32,
   parameter int              N_DOM      = 16,
   parameter int              STATUS_W   = 8,
   parameter int              BASE_LSB   = 14,
   parameter bit              RELOC_EN   = 1'b1,
   parameter logic [31:0]     PID_WINDOW = 32'h0200_0000,
   localparam int             DOM_IDX_W  = $clog2(N_DOM),
   localparam int             BASE_W     = ADDR_W - BASE_LSB
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [ADDR_W-1:0]   req_va,
   input  logic [1:0]          req_acc,
   input  logic                req_user,
   input  logic [BASE_W-1:0]   cfg_tbl_base,
   input  logic [2*N_DOM-1:0]  cfg_dom_acc,
   input  logic                cfg_xlat_en,
   input  logic [1:0]          cfg_rom_mode,
   input  logic [ADDR_W-1:0]   cfg_pid,
   output logic                busy,
   output logic                mem_req_valid,
   input  logic                mem_req_ready,
   output logic [ADDR_W-1:0]   mem_req_addr,
   input  logic                mem_rsp_valid,
   input  logic [ADDR_W-1:0]   mem_rsp_data,
   output logic                res_valid,
   output logic                res_fault,
   output logic [ADDR_W-1:0]   res_pa,
   output logic                res_rd,
   output logic                res_wr,
   output logic [STATUS_W-1:0] res_status
);

   // elaboration-time parameter checks
   if (ADDR_W != 32) begin : g_bad_addr_w
      $error("walker_top: ADDR_W must be 32");
   end
   if (N_DOM != 16) begin : g_bad_n_dom
      $error("walker_top: N_DOM must be 16 (four descriptor bits)");
   end
   if (STATUS_W < 4 + DOM_IDX_W) begin : g_bad_status_w
      $error("walker_top: STATUS_W too small for code and domain");
   end
   if (BASE_LSB != 14) begin : g_bad_base
      $error("walker_top: first-level table is 16 KB aligned");
   end

   walk_state_e          state_q;
   logic [19:0]          va_q;
   logic                 user_q;
   logic                 write_q;
   logic [2*N_DOM-1:0]   dom_q;
   logic [1:0]           rom_q;
   logic                 l1_fine_q;
   logic [DOM_IDX_W-1:0] dnum_q;
   logic [1:0]           dfield_q;
   logic [ADDR_W-1:0]    addr_q;
   logic [ADDR_W-1:0]    pa_q;
   grant_t               grant_q;
   logic [STATUS_W-1:0]  status_q;

   // process-ID relocation of low addresses
   logic [ADDR_W-1:0] va_eff;
   if (RELOC_EN) begin : g_reloc
      assign va_eff = (req_va < PID_WINDOW) ? req_va + cfg_pid : req_va;
   end else begin : g_no_reloc
      logic unused_pid;
      assign unused_pid = ^cfg_pid;
      assign va_eff     = req_va;
   end

   // first-level decode
   logic [1:0]           l1_kind;
   logic [DOM_IDX_W-1:0] l1_dom;
   logic [ADDR_W-1:0]    l1_sec_pa;
   logic [1:0]           l1_sec_ap;
   logic [ADDR_W-1:0]    l1_next;

   walker_l1_decode #(.DOM_IDX_W(DOM_IDX_W)) u_l1 (
      .desc    (mem_rsp_data),
      .va_lo   (va_q),
      .kind    (l1_kind),
      .dom_idx (l1_dom),
      .sec_pa  (l1_sec_pa),
      .sec_ap  (l1_sec_ap),
      .l2_addr (l1_next)
   );

   logic [1:0] dfield_live;
   walker_dom_sel #(.N_DOM(N_DOM)) u_dom (
      .dom_reg (dom_q),
      .idx     (l1_dom),
      .field   (dfield_live)
   );

   // second-level decode
   logic [ADDR_W-1:0] l2_pa;
   logic [1:0]        l2_ap;
   logic              l2_tfault;

   walker_l2_decode u_l2 (
      .desc        (mem_rsp_data),
      .va_lo       (va_q[15:0]),
      .l1_fine     (l1_fine_q),
      .pa          (l2_pa),
      .ap          (l2_ap),
      .trans_fault (l2_tfault)
   );

   // one shared permission checker, fed by the active level
   logic   at_l1;
   grant_t grant_live;
   assign at_l1 = (state_q == WS_L1_WAIT);

   walker_perm u_perm (
      .dom_field (at_l1 ? dfield_live : dfield_q),
      .ap        (at_l1 ? l1_sec_ap : l2_ap),
      .is_write  (write_q),
      .is_user   (user_q),
      .rom_mode  (rom_q),
      .grant     (grant_live)
   );

   logic denied;
   assign denied = !grant_live.rd && !grant_live.wr;

   function automatic logic [STATUS_W-1:0] mk_status(input logic [DOM_IDX_W-1:0] dn,
                                                     input logic [3:0] code);
      logic [STATUS_W-1:0] s;
      s = '0;
      s[3:0] = code;
      s[4 +: DOM_IDX_W] = dn;
      return s;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= WS_IDLE;
         va_q      <= '0;
         user_q    <= 1'b0;
         write_q   <= 1'b0;
         dom_q     <= '0;
         rom_q     <= '0;
         l1_fine_q <= 1'b0;
         dnum_q    <= '0;
         dfield_q  <= '0;
         addr_q    <= '0;
         pa_q      <= '0;
         grant_q   <= '{rd: 1'b0, wr: 1'b0};
         status_q  <= '0;
      end else begin
         unique case (state_q)
            WS_IDLE: begin
               if (req_valid) begin
                  va_q     <= va_eff[19:0];
                  user_q   <= req_user;
                  write_q  <= (req_acc == ACC_WRITE);
                  dom_q    <= cfg_dom_acc;
                  rom_q    <= cfg_rom_mode;
                  status_q <= '0;
                  if (!cfg_xlat_en) begin
                     pa_q    <= va_eff;
                     grant_q <= '{rd: 1'b1, wr: 1'b1};
                     state_q <= WS_FIN;
                  end else begin
                     addr_q  <= {cfg_tbl_base, va_eff[31:20], 2'b00};
                     state_q <= WS_L1_REQ;
                  end
               end
            end
            WS_L1_REQ: if (mem_req_ready) state_q <= WS_L1_WAIT;
            WS_L1_WAIT: begin
               if (mem_rsp_valid) begin
                  dnum_q    <= l1_dom;
                  dfield_q  <= dfield_live;
                  l1_fine_q <= (l1_kind == L1K_FINE);
                  pa_q      <= '0;
                  grant_q   <= '{rd: 1'b0, wr: 1'b0};
                  state_q   <= WS_FIN;
                  if (l1_kind == L1K_FAULT) begin
                     status_q <= mk_status(l1_dom, FC_L1_TRANS);
                  end else if (!dfield_live[0]) begin
                     status_q <= mk_status(l1_dom, (l1_kind == L1K_SECTION) ?
                                                   FC_SEC_DOM : FC_TBL_DOM);
                  end else if (l1_kind == L1K_SECTION) begin
                     if (denied) begin
                        status_q <= mk_status(l1_dom, FC_SEC_PERM);
                     end else begin
                        pa_q    <= l1_sec_pa;
                        grant_q <= grant_live;
                     end
                  end else begin
                     addr_q  <= l1_next;
                     state_q <= WS_L2_REQ;
                  end
               end
            end
            WS_L2_REQ: if (mem_req_ready) state_q <= WS_L2_WAIT;
            WS_L2_WAIT: begin
               if (mem_rsp_valid) begin
                  state_q <= WS_FIN;
                  if (l2_tfault) begin
                     status_q <= mk_status(dnum_q, FC_L2_TRANS);
                  end else if (denied) begin
                     status_q <= mk_status(dnum_q, FC_PG_PERM);
                  end else begin
                     pa_q    <= l2_pa;
                     grant_q <= grant_live;
                  end
               end
            end
            default: state_q <= WS_IDLE;
         endcase
      end
   end

   assign busy          = (state_q != WS_IDLE);
   assign mem_req_valid = (state_q == WS_L1_REQ) || (state_q == WS_L2_REQ);
   assign mem_req_addr  = addr_q;
   assign res_valid     = (state_q == WS_FIN);
   assign res_fault     = (status_q != '0);
   assign res_pa        = pa_q;
   assign res_rd        = grant_q.rd;
   assign res_wr        = grant_q.wr;
   assign res_status    = status_q;

   // R12
   hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

   // R12
   one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   // R11
   fault_code_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && res_fault |-> res_status[0] && !res_rd && !res_wr);

   // R9
   write_implies_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && res_wr |-> res_rd && !res_fault);

   // R12
   no_req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req_valid && !res_valid);

endmodule

// File: tb/walker_top_tb.sv
module walker_top_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_va = '0;
   logic [1:0]  req_acc = '0;
   logic        req_user = 1'b0;
   logic [17:0] cfg_tbl_base = 18'h1;   // base 0x0000_4000
   logic [31:0] cfg_dom_acc = 32'h0000_02D0;
   logic        cfg_xlat_en = 1'b0;
   logic [1:0]  cfg_rom_mode = 2'd0;
   logic [31:0] cfg_pid = '0;
   logic        busy, mem_req_valid, mem_req_ready = 1'b1;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        res_valid, res_fault, res_rd, res_wr;
   logic [31:0] res_pa;
   logic [7:0]  res_status;

   int n_checks = 0;
   int n_fails  = 0;
   int n_reads  = 0;
   int n_pulses = 0;
   bit stall_en = 1'b0;
   bit tog = 1'b0;
   bit pend = 1'b0;
   logic [31:0] pend_addr = '0;
   logic [31:0] r_pa;
   logic        r_rd, r_wr, r_fault;
   logic [7:0]  r_status;

   always #10 clk = ~clk;

   walker_top u_dut (
      .clk, .rst_n, .req_valid, .req_va, .req_acc, .req_user,
      .cfg_tbl_base, .cfg_dom_acc, .cfg_xlat_en, .cfg_rom_mode, .cfg_pid,
      .busy, .mem_req_valid, .mem_req_ready, .mem_req_addr,
      .mem_rsp_valid, .mem_rsp_data,
      .res_valid, .res_fault, .res_pa, .res_rd, .res_wr, .res_status
   );

   function automatic logic [31:0] mem_at(input logic [31:0] a);
      case (a)
         32'h0000_448C: return 32'h8760_0C42;
         32'h0000_4490: return 32'h8800_0442;
         32'h0000_4494: return 32'h8900_0062;
         32'h0000_4498: return 32'h8A00_00A2;
         32'h0000_449C: return 32'h0000_80A1;
         32'h0000_44A0: return 32'h8B00_0082;
         32'h0000_4C00: return 32'h0001_0041;
         32'h0001_0054: return 32'hABCD_E0C2;
         32'h0001_0080: return 32'h1111_1022;
         32'h0001_02B0: return 32'h5555_0401;
         32'h0001_0100: return 32'h7777_7433;
         32'h0000_4C40: return 32'h0002_0043;
         32'h0002_0008: return 32'h6666_6C03;
         default:       return 32'h0000_0000;
      endcase
   endfunction

   // read port model: one-cycle response after acceptance
   always @(negedge clk) begin
      tog = ~tog;
      mem_req_ready = !stall_en || tog;
      mem_rsp_valid = 1'b0;
      if (pend) begin
         mem_rsp_valid = 1'b1;
         mem_rsp_data  = mem_at(pend_addr);
         pend = 1'b0;
      end
      if (rst_n && mem_req_valid && mem_req_ready) begin
         pend      = 1'b1;
         pend_addr = mem_req_addr;
         n_reads++;
      end
   end

   always @(posedge clk) if (rst_n && res_valid) n_pulses++;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic walk(input logic [31:0] va, input logic [1:0] acc, input logic user);
      int waited = 0;
      @(negedge clk);
      req_valid = 1'b1; req_va = va; req_acc = acc; req_user = user;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      while (!res_valid && waited < 200) begin
         @(negedge clk);
         waited++;
      end
      if (!res_valid) chk("R12 result timeout", 32'd0, 32'd1);
      r_pa = res_pa; r_rd = res_rd; r_wr = res_wr;
      r_fault = res_fault; r_status = res_status;
   endtask

   task automatic expect_ok(input string req, input logic [31:0] pa,
                            input logic rd, input logic wr);
      chk({req, " pa"}, r_pa, pa);
      chk({req, " grant"}, {30'd0, r_rd, r_wr}, {30'd0, rd, wr});
      chk({req, " status"}, {23'd0, r_fault, r_status}, 32'd0);
   endtask

   task automatic expect_fault(input string req, input logic [7:0] st);
      chk({req, " status"}, {23'd0, r_fault, r_status}, {23'd0, 1'b1, st});
   endtask

   task automatic t_reset();
      chk("R1 reset outputs", {29'd0, res_valid, busy, mem_req_valid}, 32'd0);
   endtask

   task automatic t_passthrough();
      int reads0;
      cfg_xlat_en = 1'b0; cfg_pid = 32'h0100_0000;
      reads0 = n_reads;
      walk(32'h0000_1234, 2'b01, 1'b1);
      expect_ok("R2 R3 low relocated passthrough", 32'h0100_1234, 1'b1, 1'b1);
      walk(32'h0200_0000, 2'b00, 1'b1);
      expect_ok("R2 window edge unchanged", 32'h0200_0000, 1'b1, 1'b1);
      chk("R3 no memory reads", n_reads - reads0, 0);
      cfg_pid = '0;
   endtask

   task automatic t_sections();
      cfg_xlat_en = 1'b1;
      walk(32'h1230_0456, 2'b01, 1'b1);
      expect_ok("R6 section ap3", 32'h8760_0456, 1'b1, 1'b1);
      walk(32'h1240_0000, 2'b00, 1'b1);
      expect_fault("R6 section ap1 user", 8'h2D);
      walk(32'h1240_0010, 2'b01, 1'b0);
      expect_ok("R9 section ap1 priv", 32'h8800_0010, 1'b1, 1'b1);
      walk(32'h1250_0000, 2'b01, 1'b1);
      expect_ok("R9 manager bypass", 32'h8900_0000, 1'b1, 1'b1);
      walk(32'h1260_0000, 2'b00, 1'b0);
      expect_fault("R5 section domain 0", 8'h59);
      walk(32'h1270_0000, 2'b00, 1'b0);
      expect_fault("R5 table domain 0", 8'h5B);
      walk(32'h1280_0000, 2'b00, 1'b0);
      expect_fault("R5 section domain field 2", 8'h49);
      walk(32'h1290_0000, 2'b00, 1'b0);
      expect_fault("R4 first-level type 0", 8'h05);
   endtask

   task automatic t_pages();
      cfg_xlat_en = 1'b1;
      walk(32'h3001_5ABC, 2'b01, 1'b1);
      expect_ok("R8 small page quarter 1", 32'hABCD_EABC, 1'b1, 1'b1);
      walk(32'h3002_0000, 2'b01, 1'b1);
      expect_fault("R8 R9 ap2 user write", 8'h2F);
      walk(32'h3002_0000, 2'b10, 1'b1);
      expect_ok("R9 ap2 user fetch", 32'h1111_1000, 1'b1, 1'b0);
      walk(32'h300A_C123, 2'b00, 1'b0);
      expect_ok("R8 large page quarter 3", 32'h5555_C123, 1'b1, 1'b1);
      walk(32'h3003_0000, 2'b00, 1'b0);
      expect_fault("R7 second-level type 0", 8'h27);
      walk(32'h3004_0000, 2'b00, 1'b0);
      expect_fault("R7 tiny page in coarse", 8'h27);
      cfg_pid = 32'h3000_0000;
      walk(32'h0001_5ABC, 2'b00, 1'b0);
      expect_ok("R2 relocation before walk", 32'hABCD_EABC, 1'b1, 1'b1);
      cfg_pid = '0;
   endtask

   task automatic t_ap0();
      cfg_xlat_en = 1'b1;
      cfg_rom_mode = 2'd2;
      walk(32'h3100_2345, 2'b00, 1'b1);
      expect_ok("R10 mode 2 user read", 32'h6666_6F45, 1'b1, 1'b0);
      walk(32'h3100_2345, 2'b01, 1'b0);
      expect_fault("R10 write denied", 8'h2F);
      cfg_rom_mode = 2'd1;
      walk(32'h3100_2345, 2'b00, 1'b1);
      expect_fault("R10 mode 1 user read", 8'h2F);
      walk(32'h3100_2345, 2'b10, 1'b0);
      expect_ok("R10 mode 1 priv fetch", 32'h6666_6F45, 1'b1, 1'b0);
      cfg_rom_mode = 2'd0;
      walk(32'h3100_2345, 2'b00, 1'b0);
      expect_fault("R10 mode 0 priv read", 8'h2F);
   endtask

   task automatic t_one_walk();
      int p0;
      cfg_xlat_en = 1'b1;
      stall_en = 1'b1;
      walk(32'h3001_5ABC, 2'b00, 1'b0);
      expect_ok("R12 stalled read port", 32'hABCD_EABC, 1'b1, 1'b1);
      stall_en = 1'b0;
      repeat (3) @(negedge clk);
      p0 = n_pulses;
      req_valid = 1'b1; req_va = 32'h1230_0456; req_acc = 2'b00; req_user = 1'b0;
      @(negedge clk);
      chk("R12 busy after accept", {31'd0, busy}, 32'd1);
      req_va = 32'h1290_0000;
      repeat (2) @(negedge clk);
      req_valid = 1'b0;
      repeat (12) @(negedge clk);
      chk("R12 single result", n_pulses - p0, 1);
      chk("R12 idle after result", {31'd0, busy}, 32'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++; n_fails++;
      $display("FAIL R12 watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_passthrough();
      t_sections();
      t_pages();
      t_ap0();
      t_one_walk();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule